// File: doc/BRIEF.md
# Multi-Level Priority Interrupt Controller

This block arbitrates interrupt requests for a small accumulator-style processor core. Each of eleven sources raises a request flag whenever its condition fires. The flags are copied into a sample register once per machine cycle, and the sampled requests are filtered by a global enable and by per-source enables. Every source sits on one of four priority levels. The level is built from two bits, one taken from each of two priority registers. The enabled request with the highest level wins. Within a level, the lowest source number wins.

The controller issues an acknowledge only at an instruction boundary. It holds the acknowledge off while the instruction in progress is a return-from-interrupt or a write to an enable or priority register. It keeps an in-service bit for each level, so a request preempts a running handler only when its level is strictly higher than every level already in service. The acknowledge carries the winning source number and its call vector. A completed return-from-interrupt retires the highest level in service. Instruction execution itself lives outside the block and is seen only through handshake inputs.

Top module: `pic_core`

## Requirements
- R1: A pulse on `src_event[i]` sets `flags[i]` on the next clock edge, whatever the global and per-source enables are.
- R2: Flags are copied into the arbitration sample only on cycles where `cyc_strobe` is 1. A flag raised while the strobe is held at 0 produces no acknowledge until the strobe returns.
- R3: No acknowledge is issued while `glb_en` is 0, or for a source whose `src_en` bit is 0. The request stays pending in `flags`.
- R4: Source i has level `{prio_hi[i], prio_lo[i]}`, with `prio_hi` as the more significant bit (3 is highest, 0 is lowest). The pending enabled source on the highest level is acknowledged first.
- R5: Among pending enabled sources on the same level, the lowest source number is acknowledged first.
- R6: `ack` is a one-cycle pulse. While it is high, `ack_src` holds the winning source number and `ack_vector` equals 8 × source + 3.
- R7: When the winner's level is not strictly higher than every level in service, no acknowledge is issued. When the level is strictly higher, the request preempts and its level bit is set in `in_service` (bit n = level n).
- R8: An acknowledge is issued only in a cycle where `instr_done` is 1.
- R9: While `reti_exec` or `ctl_wr` is 1, no acknowledge is issued.
- R10: A cycle with both `reti_exec` and `instr_done` at 1 clears the highest set bit of `in_service`. A waiting request that is now strictly higher is acknowledged afterwards.
- R11: Sources whose bit is 1 in parameter `EDGE_MASK` are edge type, and their flag clears when they are acknowledged. All other sources are level type: their flag stays set after the acknowledge until a `flag_clr` pulse for that bit. The default mask makes source 1 level type and all other sources edge type.
- R12: After reset, `flags`, `in_service` and `ack` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_strobe | input | 1 | Machine-cycle sample strobe |
| src_event | input | N_SRC | Request condition pulses, one per source |
| flag_clr | input | N_SRC | Software clear of request flags |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | N_SRC | Per-source enables |
| prio_hi | input | N_SRC | Upper priority bit per source |
| prio_lo | input | N_SRC | Lower priority bit per source |
| instr_done | input | 1 | Current instruction completes this cycle |
| reti_exec | input | 1 | Instruction in progress is a return-from-interrupt |
| ctl_wr | input | 1 | Instruction in progress writes an enable or priority register |
| ack | output | 1 | Acknowledge pulse (forces the vectored call) |
| ack_src | output | IDX_W | Number of the acknowledged source |
| ack_vector | output | VEC_W | Call vector of the acknowledged source |
| flags | output | N_SRC | Current request flags |
| in_service | output | 4 | One bit per priority level in service |

## Verification
The arbitration is tried with several request patterns. Two sources on different levels fired together show whether level outranks source number. Two sources on one level fired together isolate the tie-break order. A chain of a level-2 handler, a second level-2 request and a level-3 request tells equal-level blocking apart from strictly-higher preemption. Returns issued one at a time then confirm that the waiting request is released only when the last blocking level retires. Separate patterns hold each gate closed in turn (strobe, global enable, source enable, instruction boundary, return-in-progress, control write) and release it, so that a missing gate and a gate stuck closed are both visible.

// File: rtl/pic_pkg.sv
package pic_pkg;
   localparam int LVL_W = 2;
   localparam int N_LVL = 1 << LVL_W;
   typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/pic_flag_bank.sv
module pic_flag_bank #(
   parameter int             N_SRC     = 11,
   parameter logic [63:0]    EDGE_MASK = 64'h7FD
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_strobe,
   input  logic [N_SRC-1:0] src_event,
   input  logic [N_SRC-1:0] flag_clr,
   input  logic [N_SRC-1:0] ack_clr,
   output logic [N_SRC-1:0] flags,
   output logic [N_SRC-1:0] samp
);
   logic [N_SRC-1:0] edge_m;
   logic [N_SRC-1:0] auto_clr;

   assign edge_m   = EDGE_MASK[N_SRC-1:0];
   assign auto_clr = ack_clr & edge_m;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
         samp  <= '0;
      end else begin
         flags <= (flags & ~(flag_clr | auto_clr)) | src_event;
         if (cyc_strobe) samp <= flags & ~auto_clr;
         else            samp <= samp & ~auto_clr;
      end
   end

   // R1
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_event) |=> ((flags & $past(src_event)) == $past(src_event)));

   // R2
   samp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cyc_strobe && !(|auto_clr)) |=> $stable(samp));

   // R11
   edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|auto_clr) && !(|(auto_clr & src_event))) |=> ((flags & $past(auto_clr)) == '0));
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
   import pic_pkg::*;
#(
   parameter int N_SRC = 11,
   parameter int IDX_W = $clog2(N_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] pend,
   input  logic [N_SRC-1:0] prio_hi,
   input  logic [N_SRC-1:0] prio_lo,
   output logic             win_vld,
   output logic [IDX_W-1:0] win_idx,
   output lvl_t             win_lvl
);
   logic [N_SRC-1:0] on_lvl [N_LVL];
   logic [N_LVL-1:0] lvl_hit;
   logic [N_SRC-1:0] cand;

   for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
      for (genvar s = 0; s < N_SRC; s++) begin : g_src
         assign on_lvl[l][s] = pend[s] && ({prio_hi[s], prio_lo[s]} == lvl_t'(l));
      end
      assign lvl_hit[l] = |on_lvl[l];
   end

   always_comb begin
      win_lvl = '0;
      for (int l = 0; l < N_LVL; l++) begin
         if (lvl_hit[l]) win_lvl = lvl_t'(l);
      end
   end

   assign cand    = on_lvl[win_lvl];
   assign win_vld = |lvl_hit;

   always_comb begin
      win_idx = '0;
      for (int s = N_SRC - 1; s >= 0; s--) begin
         if (cand[s]) win_idx = IDX_W'(s);
      end
   end

   // R5
   win_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_vld |-> pend[win_idx]);

   // R4
   win_top_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_vld |-> ({prio_hi[win_idx], prio_lo[win_idx]} == win_lvl));
endmodule

// File: rtl/pic_level_stack.sv
module pic_level_stack
   import pic_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  lvl_t             push_lvl,
   input  logic             pop,
   output logic [N_LVL-1:0] in_service,
   output logic             busy,
   output lvl_t             top_lvl
);
   always_comb begin
      top_lvl = '0;
      for (int l = 0; l < N_LVL; l++) begin
         if (in_service[l]) top_lvl = lvl_t'(l);
      end
   end

   assign busy = |in_service;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_service <= '0;
      end else if (push) begin
         in_service[push_lvl] <= 1'b1;
      end else if (pop && busy) begin
         in_service[top_lvl] <= 1'b0;
      end
   end

   // R7
   one_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(in_service) <= $countones($past(in_service)) + 1);

   // R10
   pop_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && busy) |=> !in_service[$past(top_lvl)]);
endmodule

// File: rtl/pic_core.sv
module pic_core
   import pic_pkg::*;
#(
   parameter int          N_SRC      = 11,
   parameter int          IDX_W      = $clog2(N_SRC),
   parameter int          VEC_W      = 16,
   parameter int          VEC_STRIDE = 8,
   parameter int          VEC_BASE   = 3,
   parameter logic [63:0] EDGE_MASK  = 64'h7FD
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_strobe,
   input  logic [N_SRC-1:0] src_event,
   input  logic [N_SRC-1:0] flag_clr,
   input  logic             glb_en,
   input  logic [N_SRC-1:0] src_en,
   input  logic [N_SRC-1:0] prio_hi,
   input  logic [N_SRC-1:0] prio_lo,
   input  logic             instr_done,
   input  logic             reti_exec,
   input  logic             ctl_wr,
   output logic             ack,
   output logic [IDX_W-1:0] ack_src,
   output logic [VEC_W-1:0] ack_vector,
   output logic [N_SRC-1:0] flags,
   output logic [N_LVL-1:0] in_service
);
   if (N_SRC < 2 || N_SRC > 64) begin : g_bad_nsrc
      $error("pic_core: N_SRC out of range");
   end
   if (VEC_STRIDE * (N_SRC - 1) + VEC_BASE >= (1 << VEC_W)) begin : g_bad_vec
      $error("pic_core: vector does not fit VEC_W");
   end

   logic [N_SRC-1:0] samp;
   logic [N_SRC-1:0] pend;
   logic [N_SRC-1:0] ack_clr;
   logic             win_vld;
   logic [IDX_W-1:0] win_idx;
   lvl_t             win_lvl;
   logic             busy;
   lvl_t             top_lvl;
   logic             outranks;
   logic             gate_open;
   logic             fire;
   logic             pop;
   logic [VEC_W-1:0] vec_c;

   pic_flag_bank #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) u_flags (
      .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe),
      .src_event(src_event), .flag_clr(flag_clr), .ack_clr(ack_clr),
      .flags(flags), .samp(samp)
   );

   assign pend = samp & src_en & {N_SRC{glb_en}};

   pic_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .pend(pend),
      .prio_hi(prio_hi), .prio_lo(prio_lo),
      .win_vld(win_vld), .win_idx(win_idx), .win_lvl(win_lvl)
   );

   assign outranks  = !busy || (win_lvl > top_lvl);
   assign gate_open = instr_done && !reti_exec && !ctl_wr;
   assign fire      = win_vld && outranks && gate_open;
   assign pop       = reti_exec && instr_done;
   assign ack_clr   = fire ? (N_SRC'(1) << win_idx) : '0;
   assign vec_c     = VEC_W'(VEC_STRIDE) * VEC_W'(win_idx) + VEC_W'(VEC_BASE);

   pic_level_stack u_stack (
      .clk(clk), .rst_n(rst_n), .push(fire), .push_lvl(win_lvl), .pop(pop),
      .in_service(in_service), .busy(busy), .top_lvl(top_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack        <= 1'b0;
         ack_src    <= '0;
         ack_vector <= '0;
      end else begin
         ack <= fire;
         if (fire) begin
            ack_src    <= win_idx;
            ack_vector <= vec_c;
         end
      end
   end

   // R8 R9
   ack_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> ($past(instr_done) && !$past(reti_exec) && !$past(ctl_wr)));

   // R6
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> in_service[{prio_hi[ack_src], prio_lo[ack_src]}]);
endmodule

// File: tb/test_pic_core.sv
module test_pic_core;
   localparam int N = 11;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cyc_strobe, glb_en, instr_done, reti_exec, ctl_wr;
   logic [N-1:0]  src_event, flag_clr, src_en, prio_hi, prio_lo;
   logic          ack;
   logic [3:0]    ack_src;
   logic [15:0]   ack_vector;
   logic [N-1:0]  flags;
   logic [3:0]    in_service;

   int n_run  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   pic_core i_pic_core (
      .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .src_event(src_event),
      .flag_clr(flag_clr), .glb_en(glb_en), .src_en(src_en), .prio_hi(prio_hi),
      .prio_lo(prio_lo), .instr_done(instr_done), .reti_exec(reti_exec),
      .ctl_wr(ctl_wr), .ack(ack), .ack_src(ack_src), .ack_vector(ack_vector),
      .flags(flags), .in_service(in_service)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; cyc_strobe = 1'b1; glb_en = 1'b1; instr_done = 1'b1;
      reti_exec = 1'b0; ctl_wr = 1'b0; src_event = '0; flag_clr = '0;
      src_en = '1; prio_hi = '0; prio_lo = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic set_lvl(input int s, input int l);
      prio_hi[s] = l[1];
      prio_lo[s] = l[0];
   endtask

   task automatic fire(input logic [N-1:0] m);
      src_event = m;
      @(negedge clk);
      src_event = '0;
   endtask

   task automatic wait_ack(input int maxc, output bit got, output int src, output int vec);
      got = 0; src = -1; vec = -1;
      for (int c = 0; c < maxc && !got; c++) begin
         @(negedge clk);
         if (ack) begin got = 1; src = int'(ack_src); vec = int'(ack_vector); end
      end
   endtask

   task automatic t_reset();
      do_reset();
      check(flags == '0, "R12 flags", int'(flags), 0);
      check(in_service == '0, "R12 in_service", int'(in_service), 0);
      check(ack == 1'b0, "R12 ack", int'(ack), 0);
   endtask

   task automatic t_enables();
      bit g; int s, v;
      do_reset();
      glb_en = 1'b0;
      fire(N'(1) << 3);
      check(flags[3] == 1'b1, "R1 flag set while disabled", int'(flags[3]), 1);
      wait_ack(6, g, s, v);
      check(!g, "R3 global enable off", int'(g), 0);
      src_en[3] = 1'b0; glb_en = 1'b1;
      wait_ack(6, g, s, v);
      check(!g, "R3 source enable off", int'(g), 0);
      src_en[3] = 1'b1;
      wait_ack(6, g, s, v);
      check(g && s == 3, "R3 released", s, 3);
   endtask

   task automatic t_strobe();
      bit g; int s, v;
      do_reset();
      cyc_strobe = 1'b0;
      fire(N'(1) << 6);
      wait_ack(6, g, s, v);
      check(!g, "R2 no strobe", int'(g), 0);
      cyc_strobe = 1'b1;
      wait_ack(6, g, s, v);
      check(g && s == 6, "R2 after strobe", s, 6);
   endtask

   task automatic t_levels();
      bit g; int s, v;
      do_reset();
      set_lvl(2, 1); set_lvl(9, 3);
      fire((N'(1) << 2) | (N'(1) << 9));
      wait_ack(6, g, s, v);
      check(g && s == 9, "R4 higher level first", s, 9);
      check(v == 8 * 9 + 3, "R6 vector", v, 75);
      @(negedge clk);
      check(ack == 1'b0, "R6 single pulse", int'(ack), 0);
      check(in_service == 4'b1000, "R7 level 3 in service", int'(in_service), 8);
   endtask

   task automatic t_tie();
      bit g; int s, v;
      do_reset();
      fire((N'(1) << 8) | (N'(1) << 7));
      wait_ack(6, g, s, v);
      check(g && s == 7, "R5 lowest index", s, 7);
      check(v == 59, "R6 vector tie", v, 59);
   endtask

   task automatic t_nesting();
      bit g; int s, v;
      do_reset();
      set_lvl(4, 2); set_lvl(5, 2); set_lvl(6, 3);
      fire(N'(1) << 4);
      wait_ack(6, g, s, v);
      check(g && s == 4, "R7 first handler", s, 4);
      fire(N'(1) << 5);
      wait_ack(6, g, s, v);
      check(!g, "R7 equal level blocked", s, -1);
      fire(N'(1) << 6);
      wait_ack(6, g, s, v);
      check(g && s == 6, "R7 higher preempts", s, 6);
      check(in_service == 4'b1100, "R7 two levels", int'(in_service), 12);
      reti_exec = 1'b1; @(negedge clk); reti_exec = 1'b0;
      check(in_service == 4'b0100, "R10 top level retired", int'(in_service), 4);
      wait_ack(6, g, s, v);
      check(!g, "R10 still blocked", s, -1);
      reti_exec = 1'b1; @(negedge clk); reti_exec = 1'b0;
      wait_ack(6, g, s, v);
      check(g && s == 5, "R10 waiting request released", s, 5);
   endtask

   task automatic t_boundary();
      bit g; int s, v;
      do_reset();
      instr_done = 1'b0;
      fire(N'(1) << 0);
      wait_ack(6, g, s, v);
      check(!g, "R8 mid-instruction", int'(g), 0);
      instr_done = 1'b1;
      wait_ack(6, g, s, v);
      check(g && s == 0, "R8 at boundary", s, 0);
   endtask

   task automatic t_holdoff();
      bit g; int s, v;
      do_reset();
      ctl_wr = 1'b1;
      fire(N'(1) << 10);
      wait_ack(6, g, s, v);
      check(!g, "R9 control write", int'(g), 0);
      ctl_wr = 1'b0; reti_exec = 1'b1;
      wait_ack(6, g, s, v);
      check(!g, "R9 return in progress", int'(g), 0);
      reti_exec = 1'b0;
      wait_ack(6, g, s, v);
      check(g && s == 10, "R9 released", s, 10);
   endtask

   task automatic t_flag_types();
      bit g; int s, v;
      do_reset();
      fire(N'(1) << 1);
      wait_ack(6, g, s, v);
      check(g && s == 1, "R11 level source ack", s, 1);
      check(flags[1] == 1'b1, "R11 level flag kept", int'(flags[1]), 1);
      flag_clr = N'(1) << 1; @(negedge clk); flag_clr = '0;
      check(flags[1] == 1'b0, "R11 level flag cleared", int'(flags[1]), 0);
      reti_exec = 1'b1; @(negedge clk); reti_exec = 1'b0;
      fire(N'(1) << 2);
      wait_ack(6, g, s, v);
      check(g && s == 2, "R11 edge source ack", s, 2);
      check(flags[2] == 1'b0, "R11 edge flag auto clear", int'(flags[2]), 0);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_enables();
      t_strobe();
      t_levels();
      t_tie();
      t_nesting();
      t_boundary();
      t_holdoff();
      t_flag_types();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule